// File: doc/BRIEF.md
# Bit-Serial Cascade Maximum Selector

This block returns the larger of two unsigned operands of a parameterised width. It is built as a chain of identical one-bit slices. The top slice looks at the most significant bit pair. Each slice passes a small decision state to the slice below it, so the result is formed bit by bit rather than by a full comparator followed by a word-wide multiplexer. Nothing is registered: the result follows the operands combinationally.

The upper two bits of the operands also feed two independent two-bit implementations, and their results appear on separate ports. One uses hand-reduced sum-of-products equations. The other uses a pair of 16-way one-bit table selectors whose data inputs are constants. The upper two bits of the larger operand equal the maximum of the two upper two-bit fields, so both side paths must always match the upper two bits of the main result.

Top module: `maxsel_chain`

## Requirements
- R1: `max_out` equals `a_in` when `a_in` > `b_in` as unsigned numbers, and `b_in` otherwise, for every operand pair.
- R2: When `a_in` equals `b_in`, `max_out` equals that common value.
- R3: The most significant bit position where the operands differ decides the winner. All lower result bits are copied from the winning operand, even where the losing operand holds ones (for 8 bits, 0x80 against 0x7F gives 0x80).
- R4: The top result bit is the OR of the two operands' top bits.
- R5: `hi_sop_out` carries the two-bit maximum of `a_in[W-1:W-2]` and `b_in[W-1:W-2]`, computed as bit1 = a1|b1 and bit0 = b1·b0 + a1·a0 + a1'·b0 + a0·b1'.
- R6: `hi_lut_out` carries the same two-bit maximum from two 16-way constant tables. The table index is {a1,a0,b1,b0}, with a1 as the index MSB.
- R7: The block is purely combinational. A change on the operands is visible on all outputs within the same time step, with no clock involved.
- R8: The slice state uses 00 for "equal so far", 10 for "A ahead" and 01 for "B ahead". The state 11 never appears, and the final state is "equal" exactly when the operands match. This is observed through R1 and R2 results at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| max_out | output | WIDTH | Larger operand, from the slice chain |
| hi_sop_out | output | 2 | Upper two-bit maximum, sum-of-products path |
| hi_lut_out | output | 2 | Upper two-bit maximum, table-selector path |

## Verification
Every output is due zero cycles after its stimulus, because no register lies on any path. The bench drives the operands just after a rising edge and reads the outputs at the following falling edge. That leaves half a period for the combinational settle and keeps sampling clear of the edge. A one-time-unit check without any clock edge confirms that the results do not wait for a clock.

// File: rtl/maxsel_pkg.sv
package maxsel_pkg;

  // Decision state carried from a more significant slice to the next one down.
  typedef enum logic [1:0] {
    ST_EQ = 2'b00,
    ST_B  = 2'b01,
    ST_A  = 2'b10
  } cmp_state_t;

  // One column of the two-bit maximum table, indexed by {a1,a0,b1,b0}.
  function automatic logic [15:0] max2_column(input int unsigned bit_sel);
    logic [15:0] col;
    logic [1:0]  av, bv, mv;
    col = '0;
    for (int unsigned idx = 0; idx < 16; idx++) begin
      av = 2'(idx >> 2);
      bv = 2'(idx);
      mv = (av > bv) ? av : bv;
      col[idx] = mv[bit_sel];
    end
    return col;
  endfunction

endpackage

// File: rtl/maxsel_cell.sv
module maxsel_cell
  import maxsel_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  cmp_state_t st_in,
  output logic       c_bit,
  output cmp_state_t st_out
);

  always_comb begin
    c_bit  = a_bit;
    st_out = st_in;
    unique case (st_in)
      ST_A: c_bit = a_bit;
      ST_B: c_bit = b_bit;
      default: begin
        c_bit = a_bit | b_bit;
        if (a_bit && !b_bit)      st_out = ST_A;
        else if (!a_bit && b_bit) st_out = ST_B;
        else                      st_out = ST_EQ;
      end
    endcase
  end

  // Guards on the slice state (R8) and on the output selection (R3).
  always_comb begin
    if (st_in != 2'b11) begin
      assert_state_legal_R8: assert (st_out != 2'b11);
    end
    if (st_in == ST_A || st_in == ST_B) begin
      assert_decision_kept_R3: assert (st_out == st_in);
    end
  end

endmodule

// File: rtl/maxsel_sop2.sv
module maxsel_sop2 (
  input  logic [1:0] a_pair,
  input  logic [1:0] b_pair,
  output logic [1:0] m_pair
);

  logic a1, a0, b1, b0;

  always_comb begin
    {a1, a0} = a_pair;
    {b1, b0} = b_pair;
    m_pair[1] = a1 | b1;
    m_pair[0] = (b1 & b0) | (a1 & a0) | (~a1 & b0) | (a0 & ~b1);
  end

endmodule

// File: rtl/maxsel_lut2.sv
module maxsel_lut2
  import maxsel_pkg::*;
(
  input  logic [1:0] a_pair,
  input  logic [1:0] b_pair,
  output logic [1:0] m_pair
);

  logic [3:0] sel_idx;
  assign sel_idx = {a_pair, b_pair};

  // One 16-way single-bit selector per output bit, with constant data inputs.
  for (genvar g = 0; g < 2; g++) begin : g_col
    localparam logic [15:0] TABLE = max2_column(g);
    assign m_pair[g] = TABLE[sel_idx];
  end

endmodule

// File: rtl/maxsel_chain.sv
module maxsel_chain
  import maxsel_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] max_out,
  output logic [1:0]       hi_sop_out,
  output logic [1:0]       hi_lut_out
);

  localparam int unsigned TOP = WIDTH - 1;
  localparam int unsigned HI2 = WIDTH - 2;

  // st_link[k] enters the slice for bit TOP-k; st_link[0] is the top entry.
  cmp_state_t st_link [WIDTH+1];

  assign st_link[0] = ST_EQ;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    maxsel_cell u_cell (
      .a_bit  (a_in[TOP-k]),
      .b_bit  (b_in[TOP-k]),
      .st_in  (st_link[k]),
      .c_bit  (max_out[TOP-k]),
      .st_out (st_link[k+1])
    );
  end

  maxsel_sop2 u_sop2 (
    .a_pair (a_in[TOP:HI2]),
    .b_pair (b_in[TOP:HI2]),
    .m_pair (hi_sop_out)
  );

  maxsel_lut2 u_lut2 (
    .a_pair (a_in[TOP:HI2]),
    .b_pair (b_in[TOP:HI2]),
    .m_pair (hi_lut_out)
  );

  // Port-level guards.
  always_comb begin
    assert_pick_operand_R1: assert (max_out == a_in || max_out == b_in);
    assert_not_below_R1:    assert (max_out >= a_in && max_out >= b_in);
    assert_top_or_R4:       assert (max_out[TOP] == (a_in[TOP] | b_in[TOP]));
    assert_sop_match_R5:    assert (hi_sop_out == max_out[TOP:HI2]);
    assert_lut_match_R6:    assert (hi_lut_out == max_out[TOP:HI2]);
    assert_equal_end_R2:    assert ((st_link[WIDTH] == ST_EQ) == (a_in == b_in));
  end

endmodule

// File: tb/maxsel_chain_bench.sv
module maxsel_chain_bench;

  localparam int unsigned W  = 8;
  localparam int unsigned WS = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a_q, b_q, m_q;
  logic [1:0]    sop_q, lut_q;
  logic [WS-1:0] as_q, bs_q, ms_q;
  logic [1:0]    sops_q, luts_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  maxsel_chain #(.WIDTH(W)) u_maxsel_chain (
    .a_in(a_q), .b_in(b_q), .max_out(m_q),
    .hi_sop_out(sop_q), .hi_lut_out(lut_q)
  );

  maxsel_chain #(.WIDTH(WS)) u_small (
    .a_in(as_q), .b_in(bs_q), .max_out(ms_q),
    .hi_sop_out(sops_q), .hi_lut_out(luts_q)
  );

  // {a, b, expected max}
  localparam logic [23:0] VEC [12] = '{
    {8'h00, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'hFF},
    {8'h80, 8'h7F, 8'h80},
    {8'h7F, 8'h80, 8'h80},
    {8'h01, 8'h00, 8'h01},
    {8'h00, 8'h01, 8'h01},
    {8'hA5, 8'hA5, 8'hA5},
    {8'hA4, 8'hA5, 8'hA5},
    {8'h5A, 8'h3C, 8'h5A},
    {8'h3C, 8'h5A, 8'h5A},
    {8'hF0, 8'h0F, 8'hF0},
    {8'h10, 8'hEF, 8'hEF}
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, a_q, b_q);
    end
  endtask

  function automatic logic [W-1:0] ref_max(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  task automatic apply_big(input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #0.5;
    a_q = a;
    b_q = b;
    @(negedge clk);
  endtask

  task automatic check_big(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] exp);
    logic [1:0] hi_exp;
    hi_exp = (a[W-1:W-2] > b[W-1:W-2]) ? a[W-1:W-2] : b[W-1:W-2];
    apply_big(a, b);
    check("R1", m_q, exp);
    check("R4", W'(m_q[W-1]), W'(a[W-1] | b[W-1]));
    check("R5", W'(sop_q), W'(hi_exp));
    check("R6", W'(lut_q), W'(hi_exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    a_q = '0; b_q = '0; as_q = '0; bs_q = '0;
    @(negedge clk);
    check("R2 start", m_q, '0);

    // Vector table
    for (int i = 0; i < 12; i++) begin
      check_big(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R3: winner's low bits copied despite loser holding ones
    apply_big(8'h40, 8'h3F);
    check("R3", m_q, 8'h40);
    apply_big(8'h24, 8'h23);
    check("R3", m_q, 8'h24);

    // R2/R8: equal operands end in the equal state, result is the common value
    for (int i = 0; i < 256; i += 17) begin
      apply_big(W'(i), W'(i));
      check("R2 R8", m_q, W'(i));
    end

    // R7: no clock edge needed
    @(negedge clk);
    a_q = 8'h33; b_q = 8'hC1;
    #1;
    check("R7", m_q, 8'hC1);
    a_q = 8'hC2;
    #1;
    check("R7", m_q, 8'hC2);

    // Exhaustive 2-bit instance: chain, SOP and table paths
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      #0.5;
      as_q = 2'(i >> 2);
      bs_q = 2'(i);
      @(negedge clk);
      begin
        logic [1:0] e2;
        e2 = (as_q > bs_q) ? as_q : bs_q;
        check("R1 small", W'(ms_q), W'(e2));
        check("R5 small", W'(sops_q), W'(e2));
        check("R6 small", W'(luts_q), W'(e2));
      end
    end

    // Random sweep of the 8-bit instance
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 5 == 0) ? (ra ^ W'(1 << (i % W))) : W'($urandom);
      check_big(ra, rb, ref_max(ra, rb));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule